// File: doc/BRIEF.md
# Floating-Point Control Word Renaming Table

This block keeps several physical copies of a single floating-point control register so that writes to it do not hold up the pipeline. Four versions of the control word can be live together. One version is the committed, architectural value. The other three are speculative values that have been written but not yet retired. A write takes the lowest-numbered free version and stores the new value there. It then makes that version the speculative current one and returns its tag. Any consumer that reads the block sees the tag, the value and the rounding mode of whichever version is current in that cycle.

Retirement is in program order. Each retire pulse commits the oldest outstanding write and returns the previously committed version to the pool. A flush drops every outstanding write at once and makes the committed version current again. Code that switches rounding to truncate before a float-to-integer conversion and then switches it back therefore costs one version per switch and no stall, as long as a version is free.

Top module: `cwr_rename_table`

## Requirements
- R1: After reset, the current tag is 0 and the current value is the reset word 16'h0F03, whose rounding field is 00. The block is ready for a write, and the tag it offers is 1.
- R2: When a write is accepted (wr_valid and wr_ready both high at a clock edge), from the next cycle rd_tag equals the wr_tag offered in that cycle and rd_data equals the written word.
- R3: The tag offered on wr_tag is the lowest-numbered free version. It never equals the committed or any outstanding version.
- R4: With no retirement, at most three writes are accepted. After the third, wr_ready is low, and a write presented while wr_ready is low changes neither the current tag nor the current value.
- R5: A retire pulse commits the oldest outstanding write and frees the previously committed version. That version is allocatable from the next cycle.
- R6: A retire pulse while no write is outstanding is ignored: the committed version is not freed.
- R7: A flush makes the committed version current in the next cycle, with its tag and value. It frees every outstanding version in that same cycle.
- R8: Flush takes priority. In a flush cycle wr_ready is low, so no write is accepted, and a retire in the same cycle is ignored.
- R9: A write and a retire in the same cycle both take effect. The write allocates from the versions that were free before that edge.
- R10: rd_rc reports bits [3:2] of the current word as the rounding mode: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 truncate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request for a new control word |
| wr_data | input | 16 | New control word value |
| wr_ready | output | 1 | A version is free and no flush is present |
| wr_tag | output | 2 | Tag the write would receive (valid while wr_ready is high) |
| ret_valid | input | 1 | Retire the oldest outstanding write |
| flush | input | 1 | Discard all outstanding writes |
| rd_tag | output | 2 | Tag of the current speculative version |
| rd_data | output | 16 | Value of the current speculative version |
| rd_rc | output | 2 | Rounding field of the current version |

## Verification
The bench goes after the full pool. A design that counts free versions wrongly would accept a fourth write and overwrite the committed word. It also goes after retirement on an empty queue, where a faulty design frees the committed version and later hands out tag 0 while it is still architectural. Flush with a write and a retire in the same cycle is exercised: a design with the wrong priority would return a non-committed tag or leak a version. A write and a retire in the same cycle are exercised too, because a queue that mishandles a push and a pop together loses the order of later commits. A long pseudo-random sweep over all input combinations compares every tag, value and rounding field against an arithmetic model of the pool.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
    localparam int NUM_VER = 4;
    localparam int CW_W    = 16;
    localparam int RC_LSB  = 2;
    localparam int TAG_W   = $clog2(NUM_VER);
    localparam int CNT_W   = TAG_W + 1;
    localparam logic [CW_W-1:0] RESET_CW = 16'h0F03;

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [CW_W-1:0]    cw_t;
    typedef logic [NUM_VER-1:0] vmask_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_DOWN    = 2'b01,
        RND_UP      = 2'b10,
        RND_CHOP    = 2'b11
    } round_mode_e;

    function automatic round_mode_e rc_of(cw_t w);
        return round_mode_e'(w[RC_LSB +: 2]);
    endfunction

    function automatic tag_t pick_lowest(vmask_t m);
        tag_t r = '0;
        for (int i = NUM_VER - 1; i >= 0; i--)
            if (m[i]) r = tag_t'(i);
        return r;
    endfunction

    function automatic vmask_t tag_onehot(tag_t t);
        vmask_t o = '0;
        o[t] = 1'b1;
        return o;
    endfunction
endpackage

// File: rtl/cwr_free_list.sv
module cwr_free_list
    import cwr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alloc_en,
    input  vmask_t release_mask,
    output vmask_t free_mask,
    output logic   any_free,
    output tag_t   alloc_tag
);
    vmask_t free_q;

    assign free_mask = free_q;
    assign any_free  = |free_q;
    assign alloc_tag = pick_lowest(free_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= ~vmask_t'(1);
        end else begin
            free_q <= (free_q & ~(alloc_en ? tag_onehot(alloc_tag) : '0)) | release_mask;
        end
    end
endmodule

// File: rtl/cwr_order_fifo.sv
module cwr_order_fifo
    import cwr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  tag_t   push_tag,
    input  logic   pop,
    input  logic   clear,
    output tag_t   head_tag,
    output logic   nonempty,
    output vmask_t occ_mask
);
    tag_t slots [NUM_VER];
    cnt_t count;
    tag_t widx;

    assign head_tag = slots[0];
    assign nonempty = (count != '0);
    assign widx     = count[TAG_W-1:0] - tag_t'(pop);

    always_comb begin
        occ_mask = '0;
        for (int i = 0; i < NUM_VER; i++)
            if (cnt_t'(i) < count) occ_mask[slots[i]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < NUM_VER; i++) slots[i] <= '0;
        end else if (clear) begin
            count <= '0;
        end else begin
            if (pop)
                for (int i = 0; i < NUM_VER - 1; i++) slots[i] <= slots[i+1];
            if (push) slots[widx] <= push_tag;
            count <= count + cnt_t'(push) - cnt_t'(pop);
        end
    end
endmodule

// File: rtl/cwr_store.sv
module cwr_store
    import cwr_pkg::*;
#(
    parameter cw_t INIT_CW = RESET_CW
) (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  tag_t waddr,
    input  cw_t  wdata,
    input  tag_t raddr,
    output cw_t  rdata
);
    cw_t mem [NUM_VER];

    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_VER; i++)
                mem[i] <= (i == 0) ? INIT_CW : '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/cwr_rename_table.sv
module cwr_rename_table
    import cwr_pkg::*;
#(
    parameter logic [cwr_pkg::CW_W-1:0] INIT_CW = cwr_pkg::RESET_CW
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    input  logic [cwr_pkg::CW_W-1:0]   wr_data,
    output logic                       wr_ready,
    output logic [cwr_pkg::TAG_W-1:0]  wr_tag,
    input  logic                       ret_valid,
    input  logic                       flush,
    output logic [cwr_pkg::TAG_W-1:0]  rd_tag,
    output logic [cwr_pkg::CW_W-1:0]   rd_data,
    output logic [1:0]                 rd_rc
);
    tag_t   spec_tag, commit_tag, alloc_tag, head_tag;
    vmask_t free_mask, occ_mask, release_mask;
    logic   any_free, nonempty, accept, do_ret;
    cw_t    cur_word;

    assign wr_ready = any_free & ~flush;
    assign accept   = wr_valid & wr_ready;
    assign do_ret   = ret_valid & ~flush & nonempty;
    assign wr_tag   = alloc_tag;

    always_comb begin
        if (flush)       release_mask = occ_mask;
        else if (do_ret) release_mask = tag_onehot(commit_tag);
        else             release_mask = '0;
    end

    cwr_free_list i_free (
        .clk, .rst,
        .alloc_en    (accept),
        .release_mask(release_mask),
        .free_mask   (free_mask),
        .any_free    (any_free),
        .alloc_tag   (alloc_tag)
    );

    cwr_order_fifo i_order (
        .clk, .rst,
        .push    (accept),
        .push_tag(alloc_tag),
        .pop     (do_ret),
        .clear   (flush),
        .head_tag(head_tag),
        .nonempty(nonempty),
        .occ_mask(occ_mask)
    );

    cwr_store #(.INIT_CW(INIT_CW)) i_store (
        .clk, .rst,
        .we    (accept),
        .waddr (alloc_tag),
        .wdata (wr_data),
        .raddr (spec_tag),
        .rdata (cur_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_tag   <= '0;
            commit_tag <= '0;
        end else begin
            if (flush)       spec_tag <= commit_tag;
            else if (accept) spec_tag <= alloc_tag;
            if (do_ret)      commit_tag <= head_tag;
        end
    end

    assign rd_tag  = spec_tag;
    assign rd_data = cur_word;
    assign rd_rc   = rc_of(cur_word);
endmodule

// File: rtl/cwr_rename_checker.sv
module cwr_rename_checker
    import cwr_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   wr_valid,
    input logic   wr_ready,
    input tag_t   wr_tag,
    input cw_t    wr_data,
    input logic   flush,
    input tag_t   rd_tag,
    input cw_t    rd_data,
    input vmask_t free_mask,
    input vmask_t occ_mask,
    input tag_t   commit_tag
);
    assert_write_visible_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (rd_tag == $past(wr_tag)) && (rd_data == $past(wr_data)));

    assert_alloc_is_free_R3: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (free_mask[wr_tag] && (wr_tag != rd_tag) && (wr_tag != commit_tag)));

    assert_pool_accounting_R4: assert property (@(posedge clk) disable iff (rst)
        ($countones(free_mask) + $countones(occ_mask) == NUM_VER - 1) &&
        ((free_mask & occ_mask) == '0) && !free_mask[commit_tag] && !occ_mask[commit_tag]);

    assert_flush_restore_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (rd_tag == $past(commit_tag)) && (occ_mask == '0));

    assert_flush_blocks_write_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> !wr_ready);
endmodule

bind cwr_rename_table cwr_rename_checker i_cwr_rename_checker (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_tag    (wr_tag),
    .wr_data   (wr_data),
    .flush     (flush),
    .rd_tag    (rd_tag),
    .rd_data   (rd_data),
    .free_mask (free_mask),
    .occ_mask  (occ_mask),
    .commit_tag(commit_tag)
);

// File: tb/test_cwr_rename_table.sv
module test_cwr_rename_table;
    import cwr_pkg::*;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0, ret_valid = 1'b0, flush = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ready;
    logic [1:0]  wr_tag, rd_tag, rd_rc;
    logic [15:0] rd_data;

    int total = 0, bad = 0;

    // reference pool
    logic [3:0]  m_free;
    int          m_q [4];
    int          m_qn, m_com, m_spec;
    logic [15:0] m_mem [4];

    always #(CLK_P/2) clk = ~clk;

    cwr_rename_table i_cwr_rename_table (
        .clk, .rst, .wr_valid, .wr_data, .wr_ready, .wr_tag,
        .ret_valid, .flush, .rd_tag, .rd_data, .rd_rc
    );

    task automatic check(input string lab, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", lab, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [3:0] m);
        for (int i = 0; i < 4; i++) if (m[i]) return i;
        return 0;
    endfunction

    task automatic model_reset();
        m_free = 4'b1110; m_qn = 0; m_com = 0; m_spec = 0;
        m_mem[0] = 16'h0F03;
        for (int i = 1; i < 4; i++) m_mem[i] = '0;
    endtask

    task automatic step(input bit w, input logic [15:0] d, input bit r, input bit f, input string lab);
        bit rdy;
        int t, old;
        wr_valid = w; wr_data = d; ret_valid = r; flush = f;
        #1;
        rdy = (m_free != 0) && !f;
        t   = lowest(m_free);
        check(lab, "wr_ready", int'(wr_ready), int'(rdy));
        if (rdy) check(lab, "wr_tag", int'(wr_tag), t);
        @(posedge clk); #1;
        if (f) begin
            for (int i = 0; i < m_qn; i++) m_free[m_q[i]] = 1'b1;
            m_qn = 0; m_spec = m_com;
        end else begin
            if (r && m_qn > 0) begin
                old = m_com; m_com = m_q[0];
                for (int i = 0; i < 3; i++) m_q[i] = m_q[i+1];
                m_qn--; m_free[old] = 1'b1;
            end
            if (w && rdy) begin
                m_free[t] = 1'b0; m_q[m_qn] = t; m_qn++;
                m_mem[t] = d; m_spec = t;
            end
        end
        wr_valid = 0; ret_valid = 0; flush = 0;
        check(lab, "rd_tag", int'(rd_tag), m_spec);
        check(lab, "rd_data", int'(rd_data), int'(m_mem[m_spec]));
        check(lab, "rd_rc", int'(rd_rc), int'(m_mem[m_spec][3:2]));
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check("R1", "rd_tag", int'(rd_tag), 0);
        check("R1", "rd_data", int'(rd_data), 16'h0F03);
        check("R1", "rd_rc", int'(rd_rc), 0);
        check("R1", "wr_ready", int'(wr_ready), 1);
        check("R1", "wr_tag", int'(wr_tag), 1);
        // R6 retire with nothing outstanding, then allocation must not yield 0
        step(0, 0, 1, 0, "R6");
        step(1, 16'h0F0F, 0, 0, "R6");
        check("R6", "rd_tag", int'(rd_tag), 1);
        step(0, 0, 0, 1, "R7");
        // R10 every rounding encoding, with R2 visibility
        for (int k = 0; k < 4; k++) begin
            step(1, 16'h0F03 | 16'(k << 2), 0, 0, "R10");
            check("R10", "rc", int'(rd_rc), k);
            step(1, 16'hA5A0 | 16'(k << 2), 1, 0, "R9");
        end
        step(0, 0, 0, 1, "R7");
        // R4 fill the pool, then an extra write is refused
        step(1, 16'h1111, 0, 0, "R2");
        step(1, 16'h222C, 0, 0, "R3");
        step(1, 16'h3334, 0, 0, "R3");
        check("R4", "wr_ready_full", int'(wr_ready), 0);
        step(1, 16'h4448, 0, 0, "R4");
        check("R4", "rd_data_kept", int'(rd_data), 16'h3334);
        // R5 retire frees the old committed version
        step(0, 0, 1, 0, "R5");
        step(1, 16'h555C, 1, 0, "R9");
        // R8 flush with simultaneous write and retire
        step(1, 16'h6660, 1, 1, "R8");
        step(1, 16'h7774, 0, 0, "R7");
        // near-exhaustive pseudo-random sweep
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 4000; n++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            step(lf[0], lf[31:16], lf[2:1] == 2'b11 || lf[3], lf[7:4] == 4'h0, "R3");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule